// File: doc/BRIEF.md
# Carry-Skip Adder with Three-Way Group Carry Selection

This block is a purely combinational binary adder of parameterised width. It adds two operands and a carry-in, returning the sum and a carry-out in the same cycle. The datapath is cut into slices of four bits. Inside a slice, each bit forms a generate term and an XOR-based propagate term, and the carry ripples from bit to bit.

At the top of each slice, the carry leaving the slice is chosen by a three-input multiplexer. Three mutually exclusive select terms drive it:
- When every bit of the slice propagates, the slice's carry-in skips straight to its carry-out.
- When the top bit does not propagate, the top bit's own generate becomes the carry-out.
- In every other case, the carry rippled into the top bit is passed through.

Only one source ever reaches the slice carry node. A long propagate run therefore crosses a whole slice in a single mux delay.

The adder is meant to be placed in a datapath wherever a single-cycle add of moderate width is needed. The width is set at elaboration and must be a multiple of four.

Top module: `csk_adder`

## Requirements
- R1: For all inputs, `{cout, sum}` equals `a + b + cin` computed at WIDTH+1 bits.
- R2: WIDTH is a parameter with default 16. A WIDTH that is not a positive multiple of 4 stops elaboration with an error. A WIDTH of 8 adds correctly for every input combination.
- R3: For bit i, the generate is `a[i] & b[i]` and the propagate is `a[i] ^ b[i]`. A bit with both operands set (for example a=b=1) yields sum 2, and a bit with one operand set yields sum 1.
- R4: Inside a slice, the carry into bit i+1 is `g[i] | (p[i] & c[i])`. Each sum bit is `p[i] ^ c[i]`, where c[i] is the carry into bit i.
- R5: In every slice, exactly one of the three carry selects (skip, top-generate, ripple) is high for every input.
- R6: When all four propagates of a slice are 1, the slice carry-out equals the slice carry-in.
- R7: When the propagate of bit 3 of a slice is 0, the slice carry-out equals `a & b` of that bit.
- R8: When bit 3 propagates but not all of bits 0 to 2 do, the slice carry-out equals the carry rippled into bit 3.
- R9: Slice 0 takes `cin` as its carry-in. Slice k takes the carry-out of slice k-1. `cout` is the carry-out of the last slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checks assume that the operands and carry-in are fully known (no X or Z). The select terms and the slice carry nodes are only meaningful for two-valued inputs. The bench drives only 0/1 values and changes inputs well before each sampling point, so the combinational network has settled when compared. The skip, top-generate and ripple checks each hold only in their own select case. The directed vectors therefore force each case: complementary operand slices for the skip case, matching top bits for the top-generate case, and low-bit generates with a propagating top bit for the ripple case.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // bits per carry-skip slice
    localparam int SLICE = 4;

    // per-bit carry terms
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // the three one-hot selects of a slice carry mux
    typedef struct packed {
        logic ripple;   // top bit propagates, lower bits do not all propagate
        logic topgen;   // top bit does not propagate
        logic skip;     // all bits propagate
    } csel_t;

    function automatic gp_t make_gp(input logic x, input logic y);
        gp_t r;
        r.g = x & y;
        r.p = x ^ y;
        return r;
    endfunction

    function automatic logic next_carry(input gp_t t, input logic c);
        return t.g | (t.p & c);
    endfunction

endpackage

// File: rtl/csk_mux3.sv
module csk_mux3 (
    input  csk_pkg::csel_t sel,
    input  logic           d_ripple,
    input  logic           d_topgen,
    input  logic           d_skip,
    output logic           y
);
    // AND-OR selection: one-hot selects mean only one term can be active
    always_comb begin
        y = (sel.ripple & d_ripple)
          | (sel.topgen & d_topgen)
          | (sel.skip   & d_skip);
    end
endmodule

// File: rtl/csk_slice.sv
module csk_slice
    import csk_pkg::*;
(
    input  logic [SLICE-1:0] a,
    input  logic [SLICE-1:0] b,
    input  logic             ci,
    output logic [SLICE-1:0] s,
    output logic             co,
    output csel_t            sel
);
    gp_t  [SLICE-1:0] gp;
    logic [SLICE-1:0] c;      // carry into each bit
    logic [SLICE-1:0] pv;
    logic             low_all;

    for (genvar i = 0; i < SLICE; i++) begin : g_bit
        assign gp[i] = make_gp(a[i], b[i]);
        assign pv[i] = gp[i].p;
        assign s[i]  = gp[i].p ^ c[i];
    end

    assign c[0] = ci;
    for (genvar i = 1; i < SLICE; i++) begin : g_chain
        assign c[i] = next_carry(gp[i-1], c[i-1]);
    end

    assign low_all    = &pv[SLICE-2:0];
    assign sel.skip   = low_all & pv[SLICE-1];
    assign sel.topgen = ~pv[SLICE-1];
    assign sel.ripple = ~low_all & pv[SLICE-1];

    csk_mux3 u_mux (
        .sel      (sel),
        .d_ripple (c[SLICE-1]),
        .d_topgen (gp[SLICE-1].g),
        .d_skip   (ci),
        .y        (co)
    );
endmodule

// File: rtl/csk_adder.sv
module csk_adder
    import csk_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NSL = WIDTH / SLICE;

    if ((WIDTH % SLICE) != 0 || WIDTH < SLICE) begin : g_bad_width
        $error("csk_adder: WIDTH must be a positive multiple of 4");
    end

    logic [NSL:0]   sl_c;
    logic [NSL-1:0] sel_skip;
    logic [NSL-1:0] sel_topgen;
    logic [NSL-1:0] sel_ripple;

    assign sl_c[0] = cin;

    for (genvar k = 0; k < NSL; k++) begin : g_slice
        csel_t sel_k;
        csk_slice u_slice (
            .a   (a[k*SLICE +: SLICE]),
            .b   (b[k*SLICE +: SLICE]),
            .ci  (sl_c[k]),
            .s   (sum[k*SLICE +: SLICE]),
            .co  (sl_c[k+1]),
            .sel (sel_k)
        );
        assign sel_skip[k]   = sel_k.skip;
        assign sel_topgen[k] = sel_k.topgen;
        assign sel_ripple[k] = sel_k.ripple;
    end

    assign cout = sl_c[NSL];
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   b,
    input logic               cin,
    input logic [WIDTH-1:0]   sum,
    input logic               cout,
    input logic [WIDTH/4:0]   sl_c,
    input logic [WIDTH/4-1:0] t_skip,
    input logic [WIDTH/4-1:0] t_topgen,
    input logic [WIDTH/4-1:0] t_ripple
);
    localparam int NSL = WIDTH / 4;

    always_comb begin
        // R1
        full_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)));
        // R9
        chain_ends_chk: assert (sl_c[0] == cin && sl_c[NSL] == cout);
        for (int k = 0; k < NSL; k++) begin
            // R5
            one_sel_chk: assert ($countones({t_skip[k], t_topgen[k], t_ripple[k]}) == 1);
            // R6
            skip_chk: assert (!t_skip[k] || sl_c[k+1] == sl_c[k]);
            // R7
            topgen_chk: assert (!t_topgen[k] || sl_c[k+1] == (a[4*k+3] & b[4*k+3]));
            // R8
            ripple_chk: assert (!t_ripple[k] ||
                sl_c[k+1] == ((4'({1'b0, a[4*k +: 3]}) + 4'({1'b0, b[4*k +: 3]})
                               + 4'(sl_c[k])) >> 3 != 4'd0));
        end
    end
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a        (a),
    .b        (b),
    .cin      (cin),
    .sum      (sum),
    .cout     (cout),
    .sl_c     (sl_c),
    .t_skip   (sel_skip),
    .t_topgen (sel_topgen),
    .t_ripple (sel_ripple)
);

// File: tb/test_csk_adder.sv
module test_csk_adder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    csk_adder #(.WIDTH(16)) i_csk_adder (
        .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
    csk_adder #(.WIDTH(8)) i_csk_adder8 (
        .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
            finish_run();
        end
    end

    // behavioural reference: plain integer addition
    task automatic t16(input logic [15:0] x, input logic [15:0] y,
                       input logic ci, input string req);
        longint unsigned ref_v;
        @(posedge clk);
        a16 = x; b16 = y; c16 = ci;
        @(negedge clk);
        ref_v = longint'(x) + longint'(y) + longint'(ci);
        n_chk++;
        if ({co16, s16} !== ref_v[16:0]) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, x, y, ci, {co16, s16}, ref_v[16:0]);
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if ({co16, s16} !== 17'd0) begin
            n_fail++;
            $display("FAIL R1 reset: actual=%h expected=0", {co16, s16});
        end
        // R3 generate and propagate
        t16(16'h0001, 16'h0001, 1'b0, "R3");
        t16(16'h0001, 16'h0000, 1'b0, "R3");
        // R4 ripple inside a slice
        t16(16'h0007, 16'h0001, 1'b0, "R4");
        t16(16'h0005, 16'h0002, 1'b1, "R4");
        // R6 skip through all-propagate slices
        t16(16'h0F0F, 16'hF0F0, 1'b1, "R6");
        t16(16'h0F0F, 16'hF0F0, 1'b0, "R6");
        t16(16'h1234, 16'hEDCB, 1'b1, "R6");
        // R7 top-bit generate
        t16(16'h0008, 16'h0008, 1'b0, "R7");
        t16(16'h8000, 16'h8000, 1'b0, "R7");
        t16(16'h0000, 16'h0000, 1'b1, "R7");
        // R8 ripple into propagating top bit
        t16(16'h000C, 16'h0004, 1'b0, "R8");
        t16(16'h0009, 16'h0000, 1'b1, "R8");
        // R9 slice chaining and cout
        t16(16'hFFFF, 16'h0000, 1'b1, "R9");
        t16(16'h00F0, 16'h0010, 1'b0, "R9");
        t16(16'h7FFF, 16'h0001, 1'b0, "R9");
        // R1 and R5: random patterns mix all three select cases
        for (int i = 0; i < 2000; i++)
            t16(16'($urandom), 16'($urandom), 1'($urandom), "R1_R5");
        // R2 exhaustive at WIDTH=8
        for (int ci = 0; ci < 2; ci++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y++) begin
                    @(posedge clk);
                    a8 = 8'(x); b8 = 8'(y); c8 = 1'(ci);
                    @(negedge clk);
                    n_chk++;
                    if ({co8, s8} !== 9'(x + y + ci)) begin
                        n_fail++;
                        $display("FAIL R2: a=%h b=%h cin=%0d actual=%h expected=%h",
                                 x, y, ci, {co8, s8}, 9'(x + y + ci));
                    end
                end
        finish_run();
    end
endmodule